// File: doc/BRIEF.md
# Memory Error Status and First-Error Log Unit

This unit sits beside a memory controller and gathers the error events that controller reports: correctable-code (ECC) faults, parity faults and accesses that fall outside the 1 MB memory window. Each event sets a flag in a 32-bit status word. Any set flag raises a single interrupt line, so software can find out why it was interrupted.

For the ECC and parity classes, the unit keeps a log register that records the address and syndrome of the first fault only. A later fault of the same class, arriving while the first-fault flag is still set, does not change the log. It sets a separate overflow flag instead. Software clears flags by writing ones to the status word. Once the first-fault flag of a class is clear again, the next fault of that class is logged afresh.

Top module: `mem_err_status`

## Requirements
- R1: After synchronous reset, the status word, both log outputs and the interrupt are all zero.
- R2: An ECC fault while bit 0 is clear sets status bit 0 on the next clock. The same edge loads the ECC log with the fault's details: address in log bits 19:0, syndrome in log bits 27:20, bits 31:28 zero.
- R3: An ECC fault while bit 0 is set leaves the ECC log unchanged and sets status bit 1.
- R4: Parity faults follow the same rule as R2 and R3, using status bit 8 (first), status bit 9 (overflow) and the parity log, which has the same field layout.
- R5: An out-of-window access event sets status bit 3, which stays set until it is cleared.
- R6: A write to the status word clears each implemented bit (0, 1, 3, 8, 9) written as 1. Bits written as 0 keep their value. The log registers are not changed by writes.
- R7: All status bits other than 0, 1, 3, 8 and 9 always read as zero, whatever is written.
- R8: The interrupt output is high exactly when at least one implemented status bit is set.
- R9: When an event sets a bit in the same cycle that a write clears that bit, the bit ends up set. A first ECC fault that coincides with a clear of bit 0 is still logged.
- R10: After bit 0 (or bit 8) has been cleared, the next fault of that class is logged as a first fault, even if the overflow bit is still set.
- R11: ECC and parity faults in the same cycle are each handled by their own class, with no effect on each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_err_i | input | 1 | ECC fault event, one cycle per fault |
| ecc_addr_i | input | 20 | Address of the ECC fault |
| ecc_syn_i | input | 8 | Syndrome of the ECC fault |
| par_err_i | input | 1 | Parity fault event, one cycle per fault |
| par_addr_i | input | 20 | Address of the parity fault |
| par_syn_i | input | 8 | Parity syndrome |
| range_err_i | input | 1 | Access outside the memory window |
| wr_en_i | input | 1 | Write strobe to the status word |
| wr_data_i | input | 32 | Write data, ones clear bits |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Interrupt request |
| ecc_log_o | output | 32 | ECC first-fault log |
| par_log_o | output | 32 | Parity first-fault log |

## Verification
The assertions assume that the event inputs and the address and syndrome inputs hold known values in every cycle after reset. They also assume each event strobe describes exactly one fault, with its details valid in the same cycle. The stimulus drives every input to a defined value on the falling edge and returns each event strobe to zero after a single cycle. The coincidence cases are driven on purpose within one cycle: fault with clear, and ECC with parity.

// File: rtl/mem_err_status_pkg.sv
package mem_err_status_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 20;
    localparam int SYN_W     = 8;
    localparam int LOG_W     = ADDR_W + SYN_W;
    localparam int NUM_CLASS = 2;          // 0: ECC, 1: parity
    localparam int CLASS_STRIDE = 8;       // bit distance between classes
    localparam int RANGE_BIT = 3;

    typedef struct packed {
        logic [SYN_W-1:0]  syn;
        logic [ADDR_W-1:0] addr;
    } err_log_t;

    typedef struct packed {
        logic first;
        logic ovf;
    } class_flags_t;

    function automatic int first_bit(input int cls);
        return cls * CLASS_STRIDE;
    endfunction

    function automatic int ovf_bit(input int cls);
        return cls * CLASS_STRIDE + 1;
    endfunction

    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            m[first_bit(c)] = 1'b1;
            m[ovf_bit(c)]   = 1'b1;
        end
        m[RANGE_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] log_to_word(input err_log_t l);
        return {{(REG_W-LOG_W){1'b0}}, l};
    endfunction

endpackage

// File: rtl/err_sticky_flag.sv
module err_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign flag_o = flag_q;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/err_class_tracker.sv
module err_class_tracker
    import mem_err_status_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         err_i,
    input  err_log_t     info_i,
    input  logic         clr_first_i,
    input  logic         clr_ovf_i,
    output class_flags_t flags_o,
    output err_log_t     log_o
);
    class_flags_t flags_q;
    err_log_t     log_q;
    logic         capture;
    logic         spill;

    assign capture = err_i & ~flags_q.first;
    assign spill   = err_i &  flags_q.first;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            log_q   <= '0;
        end else begin
            flags_q.first <= (flags_q.first & ~clr_first_i) | capture;
            flags_q.ovf   <= (flags_q.ovf   & ~clr_ovf_i)   | spill;
            if (capture) log_q <= info_i;
        end
    end

    assign flags_o = flags_q;
    assign log_o   = log_q;

    assert_first_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (err_i && !flags_o.first) |=> (flags_o.first && log_o == $past(info_i)));
    assert_log_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (err_i && flags_o.first) |=> ($stable(log_o) && flags_o.ovf));
    assert_log_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !err_i |=> $stable(log_o));
    assert_relog_R10: assert property (@(posedge clk) disable iff (rst)
        (err_i && !flags_o.first && flags_o.ovf) |=> (log_o == $past(info_i)));

endmodule

// File: rtl/mem_err_status.sv
module mem_err_status
    import mem_err_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_err_i,
    input  logic [ADDR_W-1:0] ecc_addr_i,
    input  logic [SYN_W-1:0]  ecc_syn_i,
    input  logic              par_err_i,
    input  logic [ADDR_W-1:0] par_addr_i,
    input  logic [SYN_W-1:0]  par_syn_i,
    input  logic              range_err_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  status_o,
    output logic              irq_o,
    output logic [REG_W-1:0]  ecc_log_o,
    output logic [REG_W-1:0]  par_log_o
);
    logic [REG_W-1:0] clr_vec;
    logic             err_vec   [NUM_CLASS];
    err_log_t         info_vec  [NUM_CLASS];
    class_flags_t     flag_vec  [NUM_CLASS];
    err_log_t         log_vec   [NUM_CLASS];
    logic             range_flag;

    assign clr_vec = wr_en_i ? (wr_data_i & impl_mask()) : '0;

    assign err_vec[0]  = ecc_err_i;
    assign info_vec[0] = '{syn: ecc_syn_i, addr: ecc_addr_i};
    assign err_vec[1]  = par_err_i;
    assign info_vec[1] = '{syn: par_syn_i, addr: par_addr_i};

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        err_class_tracker u_trk (
            .clk         (clk),
            .rst         (rst),
            .err_i       (err_vec[c]),
            .info_i      (info_vec[c]),
            .clr_first_i (clr_vec[first_bit(c)]),
            .clr_ovf_i   (clr_vec[ovf_bit(c)]),
            .flags_o     (flag_vec[c]),
            .log_o       (log_vec[c])
        );
    end

    err_sticky_flag u_range (
        .clk    (clk),
        .rst    (rst),
        .set_i  (range_err_i),
        .clr_i  (clr_vec[RANGE_BIT]),
        .flag_o (range_flag)
    );

    always_comb begin
        status_o = '0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            status_o[first_bit(c)] = flag_vec[c].first;
            status_o[ovf_bit(c)]   = flag_vec[c].ovf;
        end
        status_o[RANGE_BIT] = range_flag;
    end

    assign irq_o     = |status_o;
    assign ecc_log_o = log_to_word(log_vec[0]);
    assign par_log_o = log_to_word(log_vec[1]);

    assert_irq_on_event_R8: assert property (@(posedge clk) disable iff (rst)
        (ecc_err_i || par_err_i || range_err_i) |=> irq_o);
    assert_par_indep_R11: assert property (@(posedge clk) disable iff (rst)
        (!par_err_i && !wr_en_i) |=> $stable(status_o[ovf_bit(1):first_bit(1)]));
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[RANGE_BIT] && !range_err_i) |=> !status_o[RANGE_BIT]);
    always_comb begin
        if (!rst) assert_reserved_zero_R7: assert ((status_o & ~impl_mask()) == '0);
    end

endmodule

// File: tb/mem_err_status_tb.sv
module mem_err_status_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ecc_err_i = 1'b0, par_err_i = 1'b0, range_err_i = 1'b0;
    logic [19:0] ecc_addr_i = '0, par_addr_i = '0;
    logic [7:0]  ecc_syn_i = '0, par_syn_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] status_o, ecc_log_o, par_log_o;
    logic        irq_o;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mem_err_status dut_i (
        .clk(clk), .rst(rst),
        .ecc_err_i(ecc_err_i), .ecc_addr_i(ecc_addr_i), .ecc_syn_i(ecc_syn_i),
        .par_err_i(par_err_i), .par_addr_i(par_addr_i), .par_syn_i(par_syn_i),
        .range_err_i(range_err_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .status_o(status_o), .irq_o(irq_o),
        .ecc_log_o(ecc_log_o), .par_log_o(par_log_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One cycle of stimulus applied at a falling edge; results visible at the next falling edge.
    task automatic cyc(input logic e, input logic [19:0] ea, input logic [7:0] es,
                       input logic p, input logic [19:0] pa, input logic [7:0] ps,
                       input logic r, input logic we, input logic [31:0] wd);
        @(negedge clk);
        ecc_err_i = e; ecc_addr_i = ea; ecc_syn_i = es;
        par_err_i = p; par_addr_i = pa; par_syn_i = ps;
        range_err_i = r; wr_en_i = we; wr_data_i = wd;
        @(negedge clk);
        ecc_err_i = 0; par_err_i = 0; range_err_i = 0; wr_en_i = 0; wr_data_i = '0;
    endtask

    task automatic wr(input logic [31:0] d);
        cyc(0, '0, '0, 0, '0, '0, 0, 1, d);
    endtask

    task automatic t_reset;
        chk("R1 status", status_o, 32'h0);
        chk("R1 ecc log", ecc_log_o, 32'h0);
        chk("R1 par log", par_log_o, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_ecc;
        cyc(1, 20'h12345, 8'hA5, 0, '0, '0, 0, 0, '0);
        chk("R2 status", status_o, 32'h1);
        chk("R2 log", ecc_log_o, 32'h0A512345);
        chk("R8 irq", {31'b0, irq_o}, 32'h1);
        cyc(1, 20'hABCDE, 8'h3C, 0, '0, '0, 0, 0, '0);
        chk("R3 status", status_o, 32'h3);
        chk("R3 log held", ecc_log_o, 32'h0A512345);
        wr(32'h1);
        chk("R6 clear bit0 only", status_o, 32'h2);
        cyc(1, 20'h00777, 8'h11, 0, '0, '0, 0, 0, '0);
        chk("R10 status", status_o, 32'h3);
        chk("R10 relog", ecc_log_o, 32'h01100777);
        wr(32'hFFFF_FFFF);
        chk("R6 clear all", status_o, 32'h0);
        chk("R8 irq low", {31'b0, irq_o}, 32'h0);
        chk("R6 log kept", ecc_log_o, 32'h01100777);
    endtask

    task automatic t_par;
        cyc(0, '0, '0, 1, 20'hFFFFF, 8'hFF, 0, 0, '0);
        chk("R4 first", status_o, 32'h100);
        chk("R4 log", par_log_o, 32'h0FFFFFFF);
        cyc(0, '0, '0, 1, 20'h00001, 8'h02, 0, 0, '0);
        chk("R4 ovf", status_o, 32'h300);
        chk("R4 log held", par_log_o, 32'h0FFFFFFF);
        wr(32'h200);
        chk("R6 clear bit9", status_o, 32'h100);
        wr(32'h100);
        chk("R6 clear bit8", status_o, 32'h0);
    endtask

    task automatic t_range;
        cyc(0, '0, '0, 0, '0, '0, 1, 0, '0);
        chk("R5 set", status_o, 32'h8);
        repeat (3) @(negedge clk);
        chk("R5 sticky", status_o, 32'h8);
        wr(32'h0);
        chk("R6 zero write", status_o, 32'h8);
        wr(32'hFFFF_FCF4);
        chk("R7 reserved write", status_o, 32'h8);
        wr(32'h8);
        chk("R6 clear bit3", status_o, 32'h0);
    endtask

    task automatic t_collide;
        cyc(0, '0, '0, 0, '0, '0, 1, 1, 32'h8);
        chk("R9 range wins", status_o, 32'h8);
        cyc(1, 20'h0BEEF, 8'h5A, 0, '0, '0, 0, 1, 32'h1);
        chk("R9 ecc wins", status_o, 32'h9);
        chk("R9 ecc logged", ecc_log_o, 32'h05A0BEEF);
        wr(32'hFFFF_FFFF);
        chk("R6 cleanup", status_o, 32'h0);
    endtask

    task automatic t_both;
        cyc(1, 20'h11111, 8'h22, 1, 20'h33333, 8'h44, 0, 0, '0);
        chk("R11 status", status_o, 32'h101);
        chk("R11 ecc log", ecc_log_o, 32'h02211111);
        chk("R11 par log", par_log_o, 32'h04433333);
        cyc(1, 20'h55555, 8'h66, 1, 20'h77777, 8'h88, 0, 0, '0);
        chk("R11 both ovf", status_o, 32'h303);
        chk("R11 ecc held", ecc_log_o, 32'h02211111);
        chk("R11 par held", par_log_o, 32'h04433333);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ecc();
        t_par();
        t_range();
        t_collide();
        t_both();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule